// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial characters from a single receive line that is oversampled sixteen times per bit. It takes the line-control settings of the matching transmitter: a character length of five to eight bits and an optional parity bit that is odd, even or a fixed ("stick") value. Each finished character goes into a receive store as zero-extended data plus three status flags: a parity error, a framing error and a break.

The store is a single holding register when the queue enable is low and a queue of `DEPTH` entries when it is high. The consumer drains it through a valid/ready port. A character that arrives while the store is full is dropped, and a sticky overrun flag is raised. The receiver always checks exactly one stop bit. For that reason it has no two-stop input, and a sender that appends a second stop bit only adds idle time.

The control path is a five-state machine. `RX_IDLE` moves to `RX_START` when a tick finds the line low. `RX_START` returns to `RX_IDLE` if the line is high at the eighth tick, and otherwise moves to `RX_DATA`. `RX_DATA` moves to `RX_PARITY` after the last data bit when parity is enabled, and to `RX_STOP` when it is not. `RX_PARITY` moves to `RX_STOP` after one bit time. `RX_STOP` moves to `RX_IDLE` at the stop-bit midpoint, where it issues the character.

Top module: `uart_frame_rx`

## Requirements
- R1: The length code `len_sel` 00/01/10/11 selects 5/6/7/8 data bits. Bits are assembled LSB first into `rx_data`, and every bit above the selected length reads 0.
- R2: With `par_en`=1 and `stick_par`=0, a parity error is flagged if the count of ones over data and parity is odd when `even_par`=1, or even when `even_par`=0.
- R3: With `par_en`=1 and `stick_par`=1, the received parity bit must be 1 when `even_par`=0 and 0 when `even_par`=1. Any other value flags a parity error.
- R4: With `par_en`=0, no parity bit is expected and `rx_perr` is always 0.
- R5: Only the first stop bit is sampled. `rx_ferr` is 1 when it is low. A second stop bit from the sender changes nothing.
- R6: `rx_brk` is 1 when all data samples, the parity sample (if enabled) and the stop sample are low. Such a character also carries `rx_ferr`=1.
- R7: A start bit is accepted only if the line is still low at the 8th tick after the falling edge was seen. A shorter low pulse produces no character.
- R8: With `q_en`=0 the store holds one character. A character completing while it is full is discarded and `overrun` goes to 1. `overrun` stays 1 until a character is taken, and then clears.
- R9: With `q_en`=1 the store holds `DEPTH` characters, which are delivered in arrival order. The next arrival is discarded and sets `overrun`.
- R10: While `rx_valid`=1 and `rx_ready`=0, `rx_valid` and all output fields stay unchanged.
- R11: After reset, `rx_valid`=0 and `overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Raw serial receive line, idle high |
| len_sel | input | 2 | Data length code (00=5 … 11=8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| even_par | input | 1 | Even parity select (selects the stick value too) |
| stick_par | input | 1 | Fixed-value parity select |
| q_en | input | 1 | 1 = queue of DEPTH, 0 = single holding register |
| rx_ready | input | 1 | Consumer takes the head character |
| rx_valid | output | 1 | Head character present |
| rx_data | output | 8 | Zero-extended received data |
| rx_perr | output | 1 | Parity error of the head character |
| rx_ferr | output | 1 | Framing error of the head character |
| rx_brk | output | 1 | Break flag of the head character |
| overrun | output | 1 | A character was dropped on a full store |

## Verification
The assertions that compare the head character with the current `len_sel` and `par_en` assume that the line-control inputs and `q_en` change only while the store is empty and the line is idle. The bench changes settings only after it has drained every character and waited out the previous frame. The bench keeps `baud_tick` periodic, one pulse every four clocks. It holds each serial bit for exactly sixteen ticks, so every sample point falls well inside its bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    localparam int OSR = 16;
    localparam int MID = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       even_par;
        logic       stick_par;
    } rx_cfg_t;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_in,
    input  rx_cfg_t    cfg_in,
    output rx_cfg_t    cfg_q,
    output logic [7:0] data_q,
    output logic       par_q,
    output logic       stop_q,
    output logic       done
);
    localparam logic [3:0] LAST_TICK  = 4'(OSR - 1);
    localparam logic [3:0] START_TICK = 4'(MID - 1);

    rx_state_e  state, state_n;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [2:0] last_bit;
    logic       bit_end;

    assign last_bit = 3'd4 + {1'b0, cfg_q.len_sel};
    assign bit_end  = tick && (tcnt == LAST_TICK);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:   if (tick && !rx_in) state_n = RX_START;
            RX_START:  if (tick && tcnt == START_TICK)
                           state_n = rx_in ? RX_IDLE : RX_DATA;
            RX_DATA:   if (bit_end && bidx == last_bit)
                           state_n = cfg_q.par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (bit_end) state_n = RX_STOP;
            RX_STOP:   if (bit_end) state_n = RX_IDLE;
            default:   state_n = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt   <= '0;
            bidx   <= '0;
            cfg_q  <= '0;
            data_q <= '0;
            par_q  <= 1'b0;
            stop_q <= 1'b1;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE || state != state_n) tcnt <= '0;
                else                                      tcnt <= tcnt + 4'd1;
            end
            unique case (state)
                RX_START: if (state_n == RX_DATA) begin
                    cfg_q  <= cfg_in;
                    data_q <= '0;
                    bidx   <= '0;
                end
                RX_DATA: if (bit_end) begin
                    data_q[bidx] <= rx_in;
                    bidx         <= bidx + 3'd1;
                end
                RX_PARITY: if (bit_end) par_q <= rx_in;
                RX_STOP: if (bit_end) begin
                    stop_q <= rx_in;
                    done   <= 1'b1;
                end
                default: ;
            endcase
            if (state == RX_START && state_n == RX_DATA) par_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_frame_check.sv
module rx_frame_check
    import uart_rx_pkg::*;
(
    input  rx_cfg_t    cfg,
    input  logic [7:0] data,
    input  logic       par,
    input  logic       stop,
    output rx_char_t   chr
);
    logic [2:0] last_bit;
    logic [7:0] dmask;
    logic       ones_odd;
    logic       bad_par;

    assign last_bit = 3'd4 + {1'b0, cfg.len_sel};

    for (genvar i = 0; i < 8; i++) begin : g_mask
        assign dmask[i] = (3'(i) <= last_bit);
    end

    assign ones_odd = ^(data & dmask) ^ par;

    always_comb begin
        if (cfg.stick_par)     bad_par = (par != !cfg.even_par);
        else if (cfg.even_par) bad_par = ones_odd;
        else                   bad_par = !ones_odd;
    end

    assign chr.data = data & dmask;
    assign chr.perr = cfg.par_en & bad_par;
    assign chr.ferr = !stop;
    assign chr.brk  = ((data & dmask) == 8'h00) && !(cfg.par_en && par) && !stop;
endmodule

// File: rtl/rx_store.sv
module rx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     q_en,
    input  logic     push,
    input  rx_char_t wdata,
    input  logic     pop,
    output logic     valid,
    output rx_char_t head,
    output logic     overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rx_char_t        mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [AW:0]     count, cap;
    logic            accept, take;

    assign cap    = q_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
    assign valid  = (count != '0);
    assign take   = pop && valid;
    assign accept = push && ((count < cap) || take);
    assign head   = mem[rptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (take)   rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(accept) - (AW+1)'(take);
            if (push && !accept) overrun <= 1'b1;
            else if (take)       overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       even_par,
    input  logic       stick_par,
    input  logic       q_en,
    input  logic       rx_ready,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_brk,
    output logic       overrun
);
    logic       rx_s;
    rx_cfg_t    cfg_live, cfg_frm;
    logic [7:0] fdata;
    logic       fpar, fstop, fdone;
    rx_char_t   chr, head;

    assign cfg_live = '{len_sel: len_sel, par_en: par_en,
                        even_par: even_par, stick_par: stick_par};

    rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_in(rx_s),
        .cfg_in(cfg_live), .cfg_q(cfg_frm), .data_q(fdata),
        .par_q(fpar), .stop_q(fstop), .done(fdone)
    );

    rx_frame_check u_chk_frame (
        .cfg(cfg_frm), .data(fdata), .par(fpar), .stop(fstop), .chr(chr)
    );

    rx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .q_en(q_en), .push(fdone), .wdata(chr),
        .pop(rx_ready), .valid(rx_valid), .head(head), .overrun(overrun)
    );

    assign rx_data = head.data;
    assign rx_perr = head.perr;
    assign rx_ferr = head.ferr;
    assign rx_brk  = head.brk;
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] len_sel,
    input logic       par_en,
    input logic       rx_ready,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_brk,
    input logic       overrun
);
    logic [7:0] upper;
    assign upper = rx_data & ~(8'hFF >> (3 - len_sel));

    p_zero_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (upper == 8'h00));

    p_no_perr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_en) |-> !rx_perr);

    p_brk_ferr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_brk) |-> rx_ferr);

    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(rx_valid && rx_ready)) |=> overrun);

    p_ovr_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> rx_valid);

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) &&
        $stable(rx_perr) && $stable(rx_ferr) && $stable(rx_brk)));
endmodule

bind uart_frame_rx uart_frame_rx_chk u_assert (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .par_en(par_en),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .overrun(overrun)
);

// File: tb/tb_uart_frame_rx.sv
`timescale 1ns/1ps
module tb_uart_frame_rx;
    localparam int DEPTH   = 16;
    localparam int BIT_CLK = 64;   // 16 ticks of 4 clocks
    localparam int NVEC    = 11;

    logic       clk = 0, rst_n = 0, baud_tick = 0, rxd = 1;
    logic [1:0] len_sel = 2'b11;
    logic       par_en = 0, even_par = 0, stick_par = 0, q_en = 0, rx_ready = 0;
    logic       rx_valid, rx_perr, rx_ferr, rx_brk, overrun;
    logic [7:0] rx_data;
    int         errors = 0, checks = 0;
    logic [1:0] tdiv = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        tdiv      <= tdiv + 2'd1;
        baud_tick <= (tdiv == 2'd3);
    end

    uart_frame_rx #(.DEPTH(DEPTH)) dut (.*);

    // {len,pen,even,stick,two_stop,flip,stop, data, exp_data, perr,ferr,brk}
    localparam logic [26:0] VEC [NVEC] = '{
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hA5, 8'hA5, 3'b000}, // R1 8 bit
        {2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h1F, 3'b000}, // R1 5 bit
        {2'd1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h2A, 8'h2A, 3'b000}, // R2 even
        {2'd2,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h55, 8'h55, 3'b000}, // R2 odd, R5 2 stop
        {2'd3,1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 8'h3C, 8'h3C, 3'b100}, // R2 bad
        {2'd3,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1, 8'h81, 8'h81, 3'b000}, // R3 stick 1
        {2'd3,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 8'h81, 8'h81, 3'b100}, // R3 stick 0 bad
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h5A, 8'h5A, 3'b010}, // R5 frame err
        {2'd3,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 8'h00, 8'h00, 3'b111}, // R6 with parity
        {2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h13, 8'h13, 3'b000}, // R2 5 bit odd
        {2'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 8'h00, 3'b011}  // R6 R4 no parity
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        @(negedge clk) rxd = v;
        repeat (BIT_CLK - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int nb, input logic pen,
                        input logic pb, input logic stp, input logic two);
        bit_out(1'b0);
        for (int i = 0; i < nb; i++) bit_out(d[i]);
        if (pen) bit_out(pb);
        bit_out(stp);
        if (two) bit_out(1'b1);
        bit_out(1'b1);
    endtask

    task automatic wait_valid;
        for (int i = 0; i < 2000 && !rx_valid; i++) @(negedge clk);
    endtask

    task automatic take;
        @(negedge clk) rx_ready = 1;
        @(negedge clk) rx_ready = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(rx_valid == 0, "R11 valid", rx_valid, 0);
        chk(overrun == 0, "R11 overrun", overrun, 0);
        rst_n = 1;
        repeat (8) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] d, m;
            logic pb;
            int nb;
            len_sel = VEC[v][26:25]; par_en = VEC[v][24];
            even_par = VEC[v][23];   stick_par = VEC[v][22];
            nb = 5 + int'(len_sel);
            m  = 8'hFF >> (8 - nb);
            d  = VEC[v][18:11] & m;
            pb = stick_par ? !even_par : (even_par ? ^d : ~^d);
            pb = pb ^ VEC[v][20];
            send(VEC[v][18:11], nb, par_en, pb, VEC[v][19], VEC[v][21]);
            wait_valid;
            chk(rx_valid == 1, $sformatf("R1 vec%0d valid", v), rx_valid, 1);
            chk(rx_data == VEC[v][10:3], $sformatf("R1 vec%0d data", v), rx_data, VEC[v][10:3]);
            chk(rx_perr == VEC[v][2], $sformatf("R2/R3/R4 vec%0d perr", v), rx_perr, VEC[v][2]);
            chk(rx_ferr == VEC[v][1], $sformatf("R5 vec%0d ferr", v), rx_ferr, VEC[v][1]);
            chk(rx_brk == VEC[v][0], $sformatf("R6 vec%0d brk", v), rx_brk, VEC[v][0]);
            take;
        end

        // R7 short low pulse is rejected
        len_sel = 2'd3; par_en = 0; even_par = 0; stick_par = 0;
        @(negedge clk) rxd = 0;
        repeat (12) @(negedge clk);
        rxd = 1;
        repeat (2000) @(negedge clk);
        chk(rx_valid == 0, "R7 glitch ignored", rx_valid, 0);
        send(8'hC3, 8, 0, 0, 1, 0);
        wait_valid;
        chk(rx_data == 8'hC3, "R7 next frame", rx_data, 8'hC3);
        take;

        // R8 holding register overrun
        q_en = 0;
        send(8'h11, 8, 0, 0, 1, 0);
        send(8'h22, 8, 0, 0, 1, 0);
        repeat (100) @(negedge clk);
        chk(overrun == 1, "R8 overrun set", overrun, 1);
        chk(rx_data == 8'h11, "R8 first kept", rx_data, 8'h11);
        // R10 stable while not taken
        repeat (50) @(negedge clk);
        chk(rx_valid == 1 && rx_data == 8'h11, "R10 held", rx_data, 8'h11);
        take;
        chk(rx_valid == 0, "R8 single entry", rx_valid, 0);
        chk(overrun == 0, "R8 overrun cleared", overrun, 0);

        // R9 queue mode: DEPTH+1 arrivals
        q_en = 1;
        for (int i = 0; i <= DEPTH; i++) send(8'(i + 8'h40), 8, 0, 0, 1, 0);
        repeat (100) @(negedge clk);
        chk(overrun == 1, "R9 overrun on full", overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk(rx_valid == 1 && rx_data == 8'(i + 8'h40), "R9 order", rx_data, i + 8'h40);
            take;
        end
        chk(rx_valid == 0, "R9 last dropped", rx_valid, 0);
        chk(overrun == 0, "R9 overrun cleared", overrun, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule